// File: doc/BRIEF.md
# CAN Channel Mode and Bus-Off Recovery Controller

This block is the per-channel mode sequencer of a CAN controller. It holds the channel in one of four operating modes (stop, reset, halt, communication), accepts mode requests from software, and tracks the bus-off condition. It then applies one of four selectable recovery policies. Each policy decides when the channel leaves bus-off, whether it falls back to halt on its own, and whether a recovery flag and an interrupt are produced.

The bit-level protocol engine drives three inputs: a bus-off entry pulse, a pulse for each detected run of 11 recessive bits, and the error counters that this block clears through a one-cycle strobe. Software drives the mode request (a 2-bit code with a write strobe and a stop bit), the policy select, a forced-recovery strobe, and a clear strobe for the recovery flag.

All outputs are registered. A stimulus applied before a clock edge shows at the outputs right after that edge.

Top module: `can_chan_mode_ctrl`

## Requirements
- R1: After reset the mode output is stop (11), and comm_ready, rec_flag, rec_irq and err_clr are 0.
- R2: The mode output encodes communication as 00, reset as 01, halt as 10 and stop as 11. From stop, only a write of code 01 with sw_stop=0 leads to reset. A write with sw_stop=1 enters stop only while in reset and is ignored in every other mode.
- R3: After communication mode is entered, comm_ready stays 0 until the first run11 pulse. It is 0 in every other mode and while in bus-off.
- R4: Policy 00 ends bus-off on the 128th run11 pulse. On that edge err_clr pulses, rec_flag sets and rec_irq pulses. The channel becomes ready, unless halt (10) was requested during bus-off, in which case it enters halt.
- R5: Policy 01 enters halt on the bus-off entry edge, with err_clr pulsing and no rec_flag and no rec_irq.
- R6: Policy 10 keeps the channel in communication mode through bus-off. On the 128th run11 pulse it enters halt, with err_clr, rec_flag and rec_irq.
- R7: Under policy 11, a halt request during bus-off enters halt at once, with err_clr and no rec_flag. If the 128 runs complete first, rec_flag and rec_irq occur and the channel becomes ready.
- R8: A software mode write in the same cycle as bus-off entry takes precedence over the automatic halt of policies 01 and 10.
- R9: Under policy 00, force_rec during bus-off ends bus-off at once with err_clr and no rec_flag, and one further run11 makes the channel ready. Outside bus-off, or under any other policy, force_rec has no effect.
- R10: A reset request (01) during communication enters reset at the next edge, even in bus-off.
- R11: flag_clr clears rec_flag. When a set and a clear fall in the same cycle, rec_flag ends up 1.
- R12: rec_irq and err_clr are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software mode request write strobe |
| sw_code | input | 2 | Requested mode code (00 comm, 01 reset, 10 halt) |
| sw_stop | input | 1 | Stop request, honoured only in reset mode |
| policy | input | 2 | Bus-off recovery policy select |
| force_rec | input | 1 | Forced bus-off recovery strobe |
| busoff_in | input | 1 | Bus-off entry pulse from the protocol engine |
| run11 | input | 1 | Pulse per detected run of 11 recessive bits |
| flag_clr | input | 1 | Clear strobe for the recovery flag |
| mode | output | 2 | Current channel mode |
| comm_ready | output | 1 | Channel may transmit and receive |
| rec_flag | output | 1 | Sticky bus-off recovery flag |
| rec_irq | output | 1 | Recovery interrupt pulse |
| err_clr | output | 1 | Pulse that clears the error counters |

## Verification
Bus-off is not an output, so a wrong internal state has to be seen through the outputs it drives. A stuck or wrongly cleared bus-off bit shows as comm_ready returning too early, or not at all, after the next run11 pulse.

An off-by-one in the run counter moves the recovery edge by one pulse. The bench therefore checks the outputs after pulse 127, where nothing may change, and again after pulse 128.

A wrong mode request register does not show until recovery completes, when the channel ends up in the wrong mode. The bench checks the mode on the very edge where recovery completes.

// File: rtl/can_chmode_pkg.sv
package can_chmode_pkg;

    typedef enum logic [1:0] {
        MD_COMM  = 2'b00,
        MD_RESET = 2'b01,
        MD_HALT  = 2'b10,
        MD_STOP  = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        POL_STD        = 2'b00,
        POL_AUTO_HALT  = 2'b01,
        POL_HALT_AFTER = 2'b10,
        POL_SW_HALT    = 2'b11
    } rec_pol_e;

    typedef struct packed {
        chan_mode_e mode;
        chan_mode_e req;
        logic       busoff;
        logic       ready;
        logic       irq;
        logic       eclr;
    } chan_state_t;

endpackage

// File: rtl/can_run_counter.sv
module can_run_counter #(
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = $clog2(RUN_COUNT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == W'(RUN_COUNT - 1));
endmodule

// File: rtl/can_sticky_flag.sv
module can_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q = flag_q;
endmodule

// File: rtl/can_chan_mode_ctrl.sv
module can_chan_mode_ctrl
    import can_chmode_pkg::*;
#(
    parameter int RUN_COUNT = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic [1:0] sw_code,
    input  logic       sw_stop,
    input  logic [1:0] policy,
    input  logic       force_rec,
    input  logic       busoff_in,
    input  logic       run11,
    input  logic       flag_clr,
    output logic [1:0] mode,
    output logic       comm_ready,
    output logic       rec_flag,
    output logic       rec_irq,
    output logic       err_clr
);
    chan_state_t d, q;
    logic        cnt_clr, cnt_inc, cnt_last, cnt_done, flag_set;
    chan_mode_e  code;
    rec_pol_e    pol;

    assign code     = chan_mode_e'(sw_code);
    assign pol      = rec_pol_e'(policy);
    assign cnt_inc  = q.busoff && run11 && (q.mode == MD_COMM);
    assign cnt_done = cnt_inc && cnt_last;

    can_run_counter #(.RUN_COUNT(RUN_COUNT)) u_runs (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .last (cnt_last)
    );

    can_sticky_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flag_set),
        .clr  (flag_clr),
        .q    (rec_flag)
    );

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        d.eclr   = 1'b0;
        cnt_clr  = 1'b0;
        flag_set = 1'b0;
        unique case (q.mode)
            MD_STOP: begin
                if (sw_wr && !sw_stop && code == MD_RESET) begin
                    d.mode = MD_RESET;
                    d.req  = MD_RESET;
                end
            end
            MD_RESET: begin
                if (sw_wr) begin
                    if (sw_stop) begin
                        d.mode = MD_STOP;
                    end else if (code == MD_COMM || code == MD_HALT) begin
                        d.mode  = code;
                        d.req   = code;
                        d.ready = 1'b0;
                    end
                end
            end
            MD_HALT: begin
                if (sw_wr && !sw_stop && (code == MD_COMM || code == MD_RESET)) begin
                    d.mode  = code;
                    d.req   = code;
                    d.ready = 1'b0;
                end
            end
            default: begin
                if (sw_wr && !sw_stop && code != MD_STOP) begin
                    // software write wins over any automatic action this cycle
                    d.req = code;
                    if (code == MD_RESET) begin
                        d.mode   = MD_RESET;
                        d.busoff = 1'b0;
                        d.ready  = 1'b0;
                        cnt_clr  = 1'b1;
                    end else if (code == MD_HALT) begin
                        if (!q.busoff) begin
                            d.mode  = MD_HALT;
                            d.ready = 1'b0;
                        end else if (pol == POL_SW_HALT) begin
                            d.mode   = MD_HALT;
                            d.busoff = 1'b0;
                            d.ready  = 1'b0;
                            d.eclr   = 1'b1;
                            cnt_clr  = 1'b1;
                        end
                    end
                    if (d.mode == MD_COMM && busoff_in && !q.busoff) begin
                        d.busoff = 1'b1;
                        d.ready  = 1'b0;
                        cnt_clr  = 1'b1;
                    end
                end else if (q.busoff) begin
                    if (force_rec && pol == POL_STD) begin
                        d.busoff = 1'b0;
                        d.ready  = 1'b0;
                        d.eclr   = 1'b1;
                        cnt_clr  = 1'b1;
                    end else if (cnt_done) begin
                        d.busoff = 1'b0;
                        d.eclr   = 1'b1;
                        cnt_clr  = 1'b1;
                        if (pol != POL_AUTO_HALT) begin
                            flag_set = 1'b1;
                            d.irq    = 1'b1;
                        end
                        if (q.req == MD_HALT) begin
                            d.mode  = MD_HALT;
                            d.ready = 1'b0;
                        end else begin
                            d.ready = 1'b1;
                        end
                    end
                end else if (busoff_in) begin
                    d.busoff = 1'b1;
                    d.ready  = 1'b0;
                    cnt_clr  = 1'b1;
                    if (q.req == MD_COMM && pol == POL_AUTO_HALT) begin
                        d.mode   = MD_HALT;
                        d.req    = MD_HALT;
                        d.busoff = 1'b0;
                        d.eclr   = 1'b1;
                    end else if (q.req == MD_COMM && pol == POL_HALT_AFTER) begin
                        d.req = MD_HALT;
                    end
                end else if (run11) begin
                    d.ready = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode   <= MD_STOP;
            q.req    <= MD_RESET;
            q.busoff <= 1'b0;
            q.ready  <= 1'b0;
            q.irq    <= 1'b0;
            q.eclr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mode       = q.mode;
    assign comm_ready = q.ready;
    assign rec_irq    = q.irq;
    assign err_clr    = q.eclr;
endmodule

// File: rtl/can_chan_mode_chk.sv
module can_chan_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] policy,
    input logic [1:0] mode,
    input logic       comm_ready,
    input logic       rec_flag,
    input logic       rec_irq,
    input logic       err_clr
);
    // R3
    ready_in_comm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comm_ready |-> mode == 2'b00);
    // R2
    stop_from_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && $past(mode) != 2'b11) |-> $past(mode) == 2'b01);
    // R4
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_irq |-> (rec_flag && err_clr));
    // R5
    autohalt_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(policy) == 2'b01) |-> !rec_irq);
    // R12
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_irq |=> !rec_irq);
    // R12
    eclr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !err_clr);
endmodule

bind can_chan_mode_ctrl can_chan_mode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .policy    (policy),
    .mode      (mode),
    .comm_ready(comm_ready),
    .rec_flag  (rec_flag),
    .rec_irq   (rec_irq),
    .err_clr   (err_clr)
);

// File: tb/can_chan_mode_ctrl_test.sv
module can_chan_mode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr = 1'b0;
    logic [1:0] sw_code = 2'b00;
    logic       sw_stop = 1'b0;
    logic [1:0] policy = 2'b00;
    logic       force_rec = 1'b0;
    logic       busoff_in = 1'b0;
    logic       run11 = 1'b0;
    logic       flag_clr = 1'b0;
    logic [1:0] mode;
    logic       comm_ready, rec_flag, rec_irq, err_clr;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    can_chan_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_code(sw_code),
        .sw_stop(sw_stop), .policy(policy), .force_rec(force_rec),
        .busoff_in(busoff_in), .run11(run11), .flag_clr(flag_clr),
        .mode(mode), .comm_ready(comm_ready), .rec_flag(rec_flag),
        .rec_irq(rec_irq), .err_clr(err_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        sw_wr = 0; sw_stop = 0; force_rec = 0; busoff_in = 0; run11 = 0; flag_clr = 0;
    endtask

    task automatic wr(input logic [1:0] c, input logic s);
        sw_wr = 1; sw_code = c; sw_stop = s; step();
    endtask

    task automatic runs(input int n);
        for (int i = 0; i < n; i++) begin run11 = 1; step(); end
    endtask

    task automatic bus_off();
        busoff_in = 1; step();
    endtask

    task automatic go_ready(input logic [1:0] pol);
        policy = pol;
        wr(2'b01, 0); wr(2'b00, 0); runs(1);
    endtask

    task automatic t_reset_state();
        chk("R1 mode", mode, 3); chk("R1 ready", comm_ready, 0);
        chk("R1 flag", rec_flag, 0); chk("R1 irq", rec_irq, 0); chk("R1 eclr", err_clr, 0);
    endtask

    task automatic t_modes();
        wr(2'b00, 0); chk("R2 stop ignores comm", mode, 3);
        wr(2'b01, 0); chk("R2 stop to reset", mode, 1);
        wr(2'b10, 0); chk("R2 reset to halt", mode, 2);
        wr(2'b00, 1); chk("R2 stop ignored in halt", mode, 2);
        wr(2'b00, 0); chk("R3 comm not ready", mode * 2 + comm_ready, 0);
        wr(2'b00, 1); chk("R2 stop ignored in comm", mode, 0);
        runs(1); chk("R3 ready after run", comm_ready, 1);
        wr(2'b01, 0); chk("R10 reset at once", mode, 1); chk("R3 ready off", comm_ready, 0);
        wr(2'b00, 1); chk("R2 reset to stop", mode, 3);
    endtask

    task automatic t_pol00();
        go_ready(2'b00);
        bus_off(); chk("R3 not ready in busoff", comm_ready, 0);
        runs(127); chk("R4 no recovery at 127", err_clr + rec_flag + comm_ready, 0);
        run11 = 1; flag_clr = 1; step();
        chk("R4 ready", comm_ready, 1); chk("R11 set wins", rec_flag, 1);
        chk("R4 irq", rec_irq, 1); chk("R4 eclr", err_clr, 1);
        step(); chk("R12 irq pulse", rec_irq, 0); chk("R12 eclr pulse", err_clr, 0);
        flag_clr = 1; step(); chk("R11 clear", rec_flag, 0);
        bus_off(); wr(2'b10, 0); chk("R4 halt pending", mode, 0);
        runs(128); chk("R4 halt after recovery", mode, 2); chk("R4 flag", rec_flag, 1);
        flag_clr = 1; step();
    endtask

    task automatic t_pol01();
        go_ready(2'b01);
        bus_off(); chk("R5 halt at once", mode, 2); chk("R5 eclr", err_clr, 1);
        chk("R5 no flag", rec_flag + rec_irq, 0);
        go_ready(2'b01);
        busoff_in = 1; sw_wr = 1; sw_code = 2'b00; step();
        chk("R8 write wins", mode, 0); chk("R8 no eclr", err_clr, 0);
        chk("R8 in busoff", comm_ready, 0);
    endtask

    task automatic t_pol10();
        go_ready(2'b10);
        bus_off(); chk("R6 stays comm", mode, 0);
        force_rec = 1; step(); chk("R9 force ignored pol10", err_clr, 0);
        runs(127); chk("R6 not yet", mode, 0);
        runs(1); chk("R6 halt", mode, 2); chk("R6 flag", rec_flag, 1); chk("R6 irq", rec_irq, 1);
        flag_clr = 1; step();
    endtask

    task automatic t_pol11();
        go_ready(2'b11);
        bus_off(); runs(5); wr(2'b10, 0);
        chk("R7 halt early", mode, 2); chk("R7 eclr", err_clr, 1); chk("R7 no flag", rec_flag, 0);
        go_ready(2'b11);
        bus_off(); runs(128);
        chk("R7 ready after runs", comm_ready, 1); chk("R7 flag", rec_flag, 1); chk("R7 irq", rec_irq, 1);
        flag_clr = 1; step();
    endtask

    task automatic t_force();
        go_ready(2'b00);
        force_rec = 1; step(); chk("R9 ignored outside busoff", err_clr * 2 + comm_ready, 1);
        bus_off(); runs(3);
        force_rec = 1; step();
        chk("R9 eclr", err_clr, 1); chk("R9 not ready yet", comm_ready, 0); chk("R9 no flag", rec_flag, 0);
        runs(1); chk("R9 ready after run", comm_ready, 1);
        bus_off(); wr(2'b01, 0); chk("R10 reset from busoff", mode, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1;
        step();
        t_reset_state();
        t_modes();
        t_pol00();
        t_pol01();
        t_pol10();
        t_pol11();
        t_force();
        summary();
    end
endmodule